// File: doc/BRIEF.md
# Virtual Interrupt Unmask Detector

This block keeps three pieces of per-guest interrupt state: a virtual task-priority value, a virtual interrupt-enable bit and the priority of the highest pending virtual interrupt. A front end that has already decoded a guest instruction in virtual mode sends it here as one of five operation codes. For each operation the block either updates the state itself or reports an intercept, so that the hypervisor can emulate the instruction.

After each local update of the enable bit or the task priority, the block compares the pending priority with a 6-bit mask threshold built from the new state. If the pending priority lies strictly above the threshold, the block pulses a virtual-external-interrupt output for one cycle.

The hypervisor writes the pending priority through a side port and reads the task priority on a dedicated output. Detection of real faults is outside the block and arrives as a single input flag.

Top module: `vint_unmask_top`

## Requirements
- R1: The threshold is the 6-bit value {~ie, tpr[4], tpr[3:0]}, where ie is the virtual enable bit, tpr[4] is the mask-all-maskable bit and tpr[3:0] is the mask class. A virtual interrupt is raised only when the pending priority is strictly greater than this threshold. When they are equal, or the threshold is higher, no interrupt is raised.
- R2: Operation code 1 (clear-mask) and operation code 2 (set-mask) are handled locally when opt_en=1, vmode=1 and fault_in=0, and op_mask has no bit set other than bit IE_BIT. If bit IE_BIT is set, code 1 clears ie and code 2 sets ie. No intercept is reported.
- R3: A clear-mask or set-mask operation whose op_mask has any bit set other than IE_BIT reports an intercept. It leaves ie unchanged and raises no virtual interrupt.
- R4: Operation code 3 (write-status-word) always reports an intercept.
- R5: Operation code 4 (write-priority) loads op_tpr into the task priority locally when opt_en=1, vmode=1 and fault_in=0. The unmask check is then made against the new value.
- R6: Operation code 5 (read-priority) is handled locally when opt_en=1, vmode=1 and fault_in=0. The cycle after, rd_valid_o pulses and rd_data_o carries the latest task priority, including a write made in the cycle just before. At all other times rd_data_o is 0.
- R7: When fault_in=1, operation codes 1, 2, 4 and 5 report an intercept and change no state.
- R8: When opt_en=0 or vmode=0, every operation code from 1 to 5 reports an intercept and changes no state.
- R9: The unmask check runs only after a local clear-mask, set-mask or write-priority operation. A hit gives a vint_o pulse of exactly one cycle.
- R10: A hypervisor write of the pending priority takes priority over a guest operation presented in the same cycle. That guest operation is dropped with no effect and no output. A hypervisor write alone never raises vint_o.
- R11: intercept_o, vint_o, rd_valid_o and rd_data_o are registered and appear one cycle after the operation. At most one of the three pulses is high at a time. Reset clears the task priority, ie and the pending priority to 0 and clears all outputs. hv_tpr_o always shows the current task priority.
- R12: Operation codes 0, 6 and 7, and any operation with op_valid=0, have no effect and give no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opt_en | input | 1 | Enables local handling of operations |
| vmode | input | 1 | Guest runs in virtual mode |
| op_valid | input | 1 | A guest operation is presented |
| op_kind | input | 3 | Operation code (1 clear-mask, 2 set-mask, 3 write-status-word, 4 write-priority, 5 read-priority) |
| op_mask | input | MASK_W | Immediate system-mask operand of codes 1 and 2 |
| op_tpr | input | MIC_W+1 | New task priority for code 4 |
| fault_in | input | 1 | A real fault was detected for this operation |
| hv_vhpi_we | input | 1 | Hypervisor write of the pending priority |
| hv_vhpi_wdata | input | MIC_W+2 | Pending priority value to write |
| hv_tpr_o | output | MIC_W+1 | Current task priority for the hypervisor |
| intercept_o | output | 1 | Operation must be emulated by the hypervisor |
| vint_o | output | 1 | Virtual external interrupt pulse |
| rd_valid_o | output | 1 | Read-priority result valid |
| rd_data_o | output | MIC_W+1 | Read-priority result |

## Verification
Two events can meet in one cycle. The first pair is a hypervisor pending-priority write and a guest operation: the bench drives both together and expects the guest write to be absent from hv_tpr_o and every pulse output to stay low. The second pair is a write-priority followed directly by a read-priority: the bench expects the read to return the value just written. Threshold boundaries are judged against a bench model. These include pending priority equal to the threshold, one above it, and a raise while ie is clear.

// File: rtl/vint_pkg.sv
package vint_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_RSM   = 3'd1,
    OP_SSM   = 3'd2,
    OP_MTPSR = 3'd3,
    OP_MTTPR = 3'd4,
    OP_MFTPR = 3'd5
  } vop_e;

  typedef struct packed {
    logic trap;
    logic wr_ie;
    logic ie_val;
    logic wr_tpr;
    logic rd_tpr;
    logic chk;
  } vdec_t;
endpackage

// File: rtl/vint_op_classify.sv
module vint_op_classify
  import vint_pkg::*;
#(
  parameter int MASK_W = 24,
  parameter int IE_BIT = 14
) (
  input  logic              op_valid,
  input  logic [2:0]        op_kind,
  input  logic [MASK_W-1:0] op_mask,
  input  logic              fault_in,
  input  logic              opt_en,
  input  logic              vmode,
  input  logic              hv_we,
  output vdec_t             dec
);
  localparam logic [MASK_W-1:0] IE_ONEHOT = MASK_W'(1) << IE_BIT;

  logic guest, en, mask_other;

  assign guest      = op_valid && !hv_we;
  assign en         = opt_en && vmode;
  assign mask_other = |(op_mask & ~IE_ONEHOT);

  always_comb begin
    dec = '0;
    if (guest) begin
      case (op_kind)
        OP_RSM, OP_SSM: begin
          if (!en || mask_other || fault_in) begin
            dec.trap = 1'b1;
          end else begin
            dec.wr_ie  = op_mask[IE_BIT];
            dec.ie_val = (op_kind == OP_SSM);
            dec.chk    = 1'b1;
          end
        end
        OP_MTPSR: dec.trap = 1'b1;
        OP_MTTPR: begin
          if (!en || fault_in) begin
            dec.trap = 1'b1;
          end else begin
            dec.wr_tpr = 1'b1;
            dec.chk    = 1'b1;
          end
        end
        OP_MFTPR: begin
          if (!en || fault_in) dec.trap = 1'b1;
          else                 dec.rd_tpr = 1'b1;
        end
        default: dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/vint_state_regs.sv
module vint_state_regs #(
  parameter int TPR_W = 5,
  parameter int PRI_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ie,
  input  logic             ie_val,
  input  logic             wr_tpr,
  input  logic [TPR_W-1:0] tpr_wdata,
  input  logic             hv_we,
  input  logic [PRI_W-1:0] hv_wdata,
  output logic             ie_q,
  output logic [TPR_W-1:0] tpr_q,
  output logic [PRI_W-1:0] pri_q,
  output logic             ie_nx,
  output logic [TPR_W-1:0] tpr_nx
);
  assign ie_nx  = wr_ie  ? ie_val    : ie_q;
  assign tpr_nx = wr_tpr ? tpr_wdata : tpr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q  <= 1'b0;
      tpr_q <= '0;
      pri_q <= '0;
    end else begin
      ie_q  <= ie_nx;
      tpr_q <= tpr_nx;
      if (hv_we) pri_q <= hv_wdata;
    end
  end
endmodule

// File: rtl/vint_unmask_cmp.sv
module vint_unmask_cmp #(
  parameter int MIC_W = 4,
  localparam int TPR_W = MIC_W + 1,
  localparam int PRI_W = MIC_W + 2
) (
  input  logic             ie,
  input  logic [TPR_W-1:0] tpr,
  input  logic [PRI_W-1:0] pri,
  output logic             hit
);
  logic [PRI_W-1:0] thresh;

  assign thresh = {~ie, tpr[TPR_W-1], tpr[MIC_W-1:0]};
  assign hit    = pri > thresh;
endmodule

// File: rtl/vint_unmask_top.sv
module vint_unmask_top
  import vint_pkg::*;
#(
  parameter int MIC_W  = 4,
  parameter int MASK_W = 24,
  parameter int IE_BIT = 14,
  localparam int TPR_W = MIC_W + 1,
  localparam int PRI_W = MIC_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opt_en,
  input  logic              vmode,
  input  logic              op_valid,
  input  logic [2:0]        op_kind,
  input  logic [MASK_W-1:0] op_mask,
  input  logic [TPR_W-1:0]  op_tpr,
  input  logic              fault_in,
  input  logic              hv_vhpi_we,
  input  logic [PRI_W-1:0]  hv_vhpi_wdata,
  output logic [TPR_W-1:0]  hv_tpr_o,
  output logic              intercept_o,
  output logic              vint_o,
  output logic              rd_valid_o,
  output logic [TPR_W-1:0]  rd_data_o
);
  vdec_t            dec;
  logic             ie_q, ie_nx, hit_nx;
  logic [TPR_W-1:0] tpr_q, tpr_nx;
  logic [PRI_W-1:0] pri_q;

  vint_op_classify #(.MASK_W(MASK_W), .IE_BIT(IE_BIT)) u_cls (
    .op_valid(op_valid), .op_kind(op_kind), .op_mask(op_mask),
    .fault_in(fault_in), .opt_en(opt_en), .vmode(vmode),
    .hv_we(hv_vhpi_we), .dec(dec)
  );

  vint_state_regs #(.TPR_W(TPR_W), .PRI_W(PRI_W)) u_st (
    .clk(clk), .rst(rst),
    .wr_ie(dec.wr_ie), .ie_val(dec.ie_val),
    .wr_tpr(dec.wr_tpr), .tpr_wdata(op_tpr),
    .hv_we(hv_vhpi_we), .hv_wdata(hv_vhpi_wdata),
    .ie_q(ie_q), .tpr_q(tpr_q), .pri_q(pri_q),
    .ie_nx(ie_nx), .tpr_nx(tpr_nx)
  );

  vint_unmask_cmp #(.MIC_W(MIC_W)) u_cmp (
    .ie(ie_nx), .tpr(tpr_nx), .pri(pri_q), .hit(hit_nx)
  );

  assign hv_tpr_o = tpr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      intercept_o <= 1'b0;
      vint_o      <= 1'b0;
      rd_valid_o  <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      intercept_o <= dec.trap;
      vint_o      <= dec.chk && hit_nx;
      rd_valid_o  <= dec.rd_tpr;
      rd_data_o   <= dec.rd_tpr ? tpr_q : '0;
    end
  end
endmodule

// File: rtl/vint_unmask_chk.sv
module vint_unmask_chk #(
  parameter int TPR_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             opt_en,
  input logic             vmode,
  input logic             op_valid,
  input logic [2:0]       op_kind,
  input logic             fault_in,
  input logic             hv_vhpi_we,
  input logic [TPR_W-1:0] hv_tpr_o,
  input logic             intercept_o,
  input logic             vint_o,
  input logic             rd_valid_o
);
  logic guest, listed, upd_kind;
  assign guest    = op_valid && !hv_vhpi_we;
  assign listed   = (op_kind >= 3'd1) && (op_kind <= 3'd5);
  assign upd_kind = (op_kind == 3'd1) || (op_kind == 3'd2) || (op_kind == 3'd4);

  assert_excl_out_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({intercept_o, vint_o, rd_valid_o}));

  assert_mtpsr_trap_R4: assert property (@(posedge clk) disable iff (rst)
    (guest && op_kind == 3'd3) |=> intercept_o);

  assert_hv_prio_R10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && hv_vhpi_we) |=> !(intercept_o || vint_o || rd_valid_o));

  assert_disabled_trap_R8: assert property (@(posedge clk) disable iff (rst)
    (guest && listed && (!opt_en || !vmode)) |=> intercept_o);

  assert_fault_trap_R7: assert property (@(posedge clk) disable iff (rst)
    (guest && listed && fault_in) |=> intercept_o);

  assert_vint_source_R9: assert property (@(posedge clk) disable iff (rst)
    (!(guest && upd_kind)) |=> !vint_o);

  assert_tpr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!(guest && op_kind == 3'd4)) |=> $stable(hv_tpr_o));
endmodule

bind vint_unmask_top vint_unmask_chk #(.TPR_W(TPR_W)) u_chk (
  .clk(clk), .rst(rst), .opt_en(opt_en), .vmode(vmode),
  .op_valid(op_valid), .op_kind(op_kind), .fault_in(fault_in),
  .hv_vhpi_we(hv_vhpi_we), .hv_tpr_o(hv_tpr_o),
  .intercept_o(intercept_o), .vint_o(vint_o), .rd_valid_o(rd_valid_o)
);

// File: tb/vint_unmask_top_tb.sv
module vint_unmask_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MIC_W  = 4;
  localparam int MASK_W = 24;
  localparam int IE_BIT = 14;
  localparam int TPR_W  = MIC_W + 1;
  localparam int PRI_W  = MIC_W + 2;
  localparam logic [MASK_W-1:0] IEM = MASK_W'(1) << IE_BIT;

  logic clk = 1'b0, rst = 1'b1;
  logic opt_en = 1'b0, vmode = 1'b0, op_valid = 1'b0, fault_in = 1'b0, hv_vhpi_we = 1'b0;
  logic [2:0]        op_kind = '0;
  logic [MASK_W-1:0] op_mask = '0;
  logic [TPR_W-1:0]  op_tpr = '0;
  logic [PRI_W-1:0]  hv_vhpi_wdata = '0;
  logic [TPR_W-1:0]  hv_tpr_o, rd_data_o;
  logic              intercept_o, vint_o, rd_valid_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic             icpt;
    logic             vint;
    logic             rdv;
    logic [TPR_W-1:0] rdd;
    logic [TPR_W-1:0] tpr;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  logic             m_ie  = 1'b0;
  logic [TPR_W-1:0] m_tpr = '0;
  logic [PRI_W-1:0] m_pri = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vint_unmask_top #(.MIC_W(MIC_W), .MASK_W(MASK_W), .IE_BIT(IE_BIT)) dut_i (
    .clk(clk), .rst(rst), .opt_en(opt_en), .vmode(vmode),
    .op_valid(op_valid), .op_kind(op_kind), .op_mask(op_mask), .op_tpr(op_tpr),
    .fault_in(fault_in), .hv_vhpi_we(hv_vhpi_we), .hv_vhpi_wdata(hv_vhpi_wdata),
    .hv_tpr_o(hv_tpr_o), .intercept_o(intercept_o), .vint_o(vint_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: pop one expectation per clock once the driver has queued it
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, "intercept", int'(intercept_o), int'(e.icpt));
      check(t, "vint",      int'(vint_o),      int'(e.vint));
      check(t, "rd_valid",  int'(rd_valid_o),  int'(e.rdv));
      check(t, "rd_data",   int'(rd_data_o),   int'(e.rdd));
      check(t, "hv_tpr",    int'(hv_tpr_o),    int'(e.tpr));
    end
  end

  function automatic logic model_hit();
    logic [PRI_W-1:0] th;
    th = {~m_ie, m_tpr};
    return m_pri > th;
  endfunction

  task automatic drive(logic v, logic [2:0] k, logic [MASK_W-1:0] msk,
                       logic [TPR_W-1:0] tp, logic flt, logic oe, logic vm,
                       logic hwe, logic [PRI_W-1:0] hwd, string tag);
    exp_t e;
    logic en;
    @(negedge clk);
    op_valid = v; op_kind = k; op_mask = msk; op_tpr = tp; fault_in = flt;
    opt_en = oe; vmode = vm; hv_vhpi_we = hwe; hv_vhpi_wdata = hwd;
    e  = '0;
    en = oe && vm && !flt;
    if (hwe) begin
      m_pri = hwd;
    end else if (v) begin
      case (k)
        3'd1, 3'd2: begin
          if (!en || |(msk & ~IEM)) e.icpt = 1'b1;
          else begin
            if (msk[IE_BIT]) m_ie = (k == 3'd2);
            e.vint = model_hit();
          end
        end
        3'd3: e.icpt = 1'b1;
        3'd4: begin
          if (!en) e.icpt = 1'b1;
          else begin m_tpr = tp; e.vint = model_hit(); end
        end
        3'd5: begin
          if (!en) e.icpt = 1'b1;
          else begin e.rdv = 1'b1; e.rdd = m_tpr; end
        end
        default: ;
      endcase
    end
    e.tpr = m_tpr;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic gop(logic [2:0] k, logic [MASK_W-1:0] msk, logic [TPR_W-1:0] tp, string tag);
    drive(1'b1, k, msk, tp, 1'b0, 1'b1, 1'b1, 1'b0, '0, tag);
  endtask

  task automatic hvw(logic [PRI_W-1:0] d, string tag);
    drive(1'b0, 3'd0, '0, '0, 1'b0, 1'b1, 1'b1, 1'b1, d, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R11 reset state
    check("R11", "rst_intercept", int'(intercept_o), 0);
    check("R11", "rst_vint",      int'(vint_o), 0);
    check("R11", "rst_rd_valid",  int'(rd_valid_o), 0);
    check("R11", "rst_tpr",       int'(hv_tpr_o), 0);

    hvw(6'd37, "R10_hv_alone");                 // no raise from hv write alone
    gop(3'd2, IEM, '0, "R2_ssm_ie");            // ie=1, thr 0 < 37: raise
    gop(3'd4, '0, 5'h1F, "R5_mttpr_1f");        // thr 31 < 37: raise
    hvw(6'd31, "R10_hv_31");
    gop(3'd4, '0, 5'h1F, "R1_equal_masked");    // 31 == 31: no raise
    gop(3'd4, '0, 5'h1E, "R1_one_above");       // 31 > 30: raise
    gop(3'd5, '0, '0, "R6_read");
    gop(3'd1, IEM, '0, "R2_rsm_ie");            // ie=0, thr 62
    gop(3'd2, IEM | 24'h1, '0, "R3_ssm_extra");  // intercept, ie stays 0
    gop(3'd4, '0, 5'h00, "R3_ie_unchanged");    // thr 32 > 31: no raise
    gop(3'd3, '0, '0, "R4_mtpsr");
    drive(1'b1, 3'd4, '0, 5'h07, 1'b1, 1'b1, 1'b1, 1'b0, '0, "R7_fault_mttpr");
    drive(1'b1, 3'd2, IEM, '0, 1'b1, 1'b1, 1'b1, 1'b0, '0, "R7_fault_ssm");
    drive(1'b1, 3'd2, IEM, '0, 1'b0, 1'b0, 1'b1, 1'b0, '0, "R8_opt_off_ssm");
    drive(1'b1, 3'd5, '0, '0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R8_vmode_off_read");
    drive(1'b1, 3'd4, '0, 5'h03, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R8_both_off_mttpr");
    hvw(6'd63, "R10_hv_63");
    gop(3'd4, '0, 5'h00, "R1_raise_ie_clear");  // 63 > 32 with ie=0
    drive(1'b1, 3'd4, '0, 5'h1F, 1'b0, 1'b1, 1'b1, 1'b1, 6'd2, "R10_same_cycle");
    gop(3'd4, '0, 5'h15, "R9_mttpr_no_hit");    // ie=0, thr 53 > 2
    gop(3'd5, '0, '0, "R6_read_after_write");
    gop(3'd0, IEM, 5'h1F, "R12_code0");
    gop(3'd6, IEM, 5'h1F, "R12_code6");
    gop(3'd7, IEM, 5'h1F, "R12_code7");
    drive(1'b0, 3'd4, '0, 5'h1F, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R12_not_valid");
    gop(3'd2, '0, '0, "R9_ssm_empty_mask");     // local, ie stays 0, no hit
    gop(3'd2, IEM, '0, "R9_ssm_hit");           // ie=1, thr 21 > 2: no hit
    hvw(6'd40, "R10_hv_40");
    gop(3'd5, '0, '0, "R9_read_no_check");      // read never raises
    gop(3'd2, IEM, '0, "R9_ssm_again_hit");     // 40 > 21: raise
    for (int i = 0; i < 4; i++) gop(3'd0, '0, '0, "R9_idle_after_pulse");
    while (exp_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule